// File: doc/BRIEF.md
# Vector Indexed Address Sequencer

This block walks through the elements of a vector indexed load or store and produces one effective address for each element. A start strobe captures the operation: the mode field, the element-width override code, whether the base and the index operand are vectors or scalars, and a vector length. The block then issues one address request per element, in ascending element order, over a valid/ready handshake. Each request carries the destination element number.

For every element the block presents two read selectors, one for the base operand and one for the index operand. The surrounding register file answers combinationally in the same cycle. The address is the base value plus the index value. The index is first reduced to the overridden element width and then extended back to 64 bits, by sign or by zero depending on the mode.

Independently of the sequencing, the block decodes the live 5-bit indexed-mode field into a set of flags for the rest of the pipeline.

Top module: `vidx_addr_seq`

## Requirements
- R1: After reset, req_valid, done and busy are all low.
- R2: The mode field is numbered so that mode[4:3] is the major mode, mode[2] is the mode bit, mode[1] is flag A and mode[0] is flag B.
  - Major 00 with mode bit 0 gives `m_normal`, with dz = A and sz = B.
  - Major 00 with mode bit 1 gives `m_sea`, with dz = A and sea = B.
  - In both cases all other flags are 0.
- R3: Major 01 gives `m_ffirst`, with inv = mode bit.
  - When rc is 1, crsel = {A,B} and dz = rc1 = 0.
  - When rc is 0, dz = A, rc1 = B and crsel = 0.
- R4: Major 10 gives `m_sat`, with sgn = mode bit, dz = A and sz = B. Major 11 raises no flag at all.
- R5: The width code is 00=64, 01=32, 10=16, 11=8 bits. When the captured mode is not SEA-active, the index is truncated to the coded width and zero-extended.
- R6: SEA-active means major 00, mode bit 1 and B = 1. Under SEA-active with a width code other than 00, the truncated index is sign-extended from the coded width.
- R7: With width code 00, the full 64-bit index is used unchanged, whether or not SEA-active holds.
- R8: For element i, each read selector is i when its operand is marked vector and 0 when it is marked scalar.
- R9: The address is base plus extended index, modulo 2^64.
- R10: Requests go out for elements 0..vl-1 in ascending order, one per accepted handshake. While req_ready is low, req_valid stays high and the element number does not change.
- R11: done pulses for one cycle in the cycle after the last element is accepted. A start with vl = 0 pulses done in the next cycle and issues no request.
- R12: With scalar base and scalar index and vl = n, exactly n separate requests go out, all to the same address, with destination elements 0..n-1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures an operation when idle |
| mode_i | input | 5 | Indexed-mode field |
| rc_i | input | 1 | Record bit, used only to decode fail-first |
| ew_i | input | 2 | Element-width override code for the index |
| base_vec_i | input | 1 | Base operand is a vector |
| idx_vec_i | input | 1 | Index operand is a vector |
| vl_i | input | VLW | Vector length |
| busy_o | output | 1 | Operation in progress |
| base_sel_o | output | VLW | Base element to read |
| idx_sel_o | output | VLW | Index element to read |
| base_val_i | input | AW | Base element value |
| idx_val_i | input | AW | Index element value |
| req_valid_o | output | 1 | Address request valid |
| req_ready_i | input | 1 | Address request accepted |
| req_addr_o | output | AW | Effective address |
| req_elem_o | output | VLW | Destination element number |
| done_o | output | 1 | Last element accepted |
| m_normal_o | output | 1 | Normal mode |
| m_sea_o | output | 1 | Signed-address mode |
| m_ffirst_o | output | 1 | Fail-first mode |
| m_sat_o | output | 1 | Saturation mode |
| m_sgn_o | output | 1 | Signed saturation |
| m_inv_o | output | 1 | Fail-first invert |
| m_dz_o | output | 1 | dz flag |
| m_sz_o | output | 1 | sz flag |
| m_sea_flag_o | output | 1 | SEA flag |
| m_rc1_o | output | 1 | RC1 flag |
| m_crsel_o | output | 2 | Condition bit selector |

## Verification
The assertions check several properties on every cycle:
- the handshake holds the request steady while it is stalled;
- the element number advances by one after each accepted request;
- done never coincides with a pending request;
- the decoder raises at most one mode class;
- the read selectors stay at zero for scalar operands.

Only the bench scenarios can show the arithmetic itself. A scoreboard computes each expected address and compares it against the request stream under irregular backpressure. This covers truncation to each element width, sign versus zero extension, 64-bit wrap, the full-width case, and the repeated same-address requests of a scalar splat.

// File: rtl/vidx_addr_seq.sv
module vidx_addr_seq #(
  parameter int AW  = 64,
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [4:0]     mode_i,
  input  logic           rc_i,
  input  logic [1:0]     ew_i,
  input  logic           base_vec_i,
  input  logic           idx_vec_i,
  input  logic [VLW-1:0] vl_i,
  output logic           busy_o,
  output logic [VLW-1:0] base_sel_o,
  output logic [VLW-1:0] idx_sel_o,
  input  logic [AW-1:0]  base_val_i,
  input  logic [AW-1:0]  idx_val_i,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [AW-1:0]  req_addr_o,
  output logic [VLW-1:0] req_elem_o,
  output logic           done_o,
  output logic           m_normal_o,
  output logic           m_sea_o,
  output logic           m_ffirst_o,
  output logic           m_sat_o,
  output logic           m_sgn_o,
  output logic           m_inv_o,
  output logic           m_dz_o,
  output logic           m_sz_o,
  output logic           m_sea_flag_o,
  output logic           m_rc1_o,
  output logic [1:0]     m_crsel_o
);
  localparam logic [1:0] EW64 = 2'b00, EW32 = 2'b01, EW16 = 2'b10, EW8 = 2'b11;

  logic [1:0]     major;
  logic           mbit, fa, fb;
  assign major = mode_i[4:3];
  assign mbit  = mode_i[2];
  assign fa    = mode_i[1];
  assign fb    = mode_i[0];

  always_comb begin
    m_normal_o   = 1'b0;
    m_sea_o      = 1'b0;
    m_ffirst_o   = 1'b0;
    m_sat_o      = 1'b0;
    m_sgn_o      = 1'b0;
    m_inv_o      = 1'b0;
    m_dz_o       = 1'b0;
    m_sz_o       = 1'b0;
    m_sea_flag_o = 1'b0;
    m_rc1_o      = 1'b0;
    m_crsel_o    = 2'b00;
    case (major)
      2'b00: begin
        m_dz_o = fa;
        if (mbit) begin
          m_sea_o      = 1'b1;
          m_sea_flag_o = fb;
        end else begin
          m_normal_o = 1'b1;
          m_sz_o     = fb;
        end
      end
      2'b01: begin
        m_ffirst_o = 1'b1;
        m_inv_o    = mbit;
        if (rc_i) m_crsel_o = {fa, fb};
        else begin
          m_dz_o  = fa;
          m_rc1_o = fb;
        end
      end
      2'b10: begin
        m_sat_o = 1'b1;
        m_sgn_o = mbit;
        m_dz_o  = fa;
        m_sz_o  = fb;
      end
      default: ;
    endcase
  end

  logic           busy_q, done_q, sea_q, bvec_q, ivec_q;
  logic [1:0]     ew_q;
  logic [VLW-1:0] vl_q, cnt_q;
  logic           fire, last;

  assign fire = busy_q && req_ready_i;
  assign last = (cnt_q == vl_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sea_q  <= 1'b0;
      bvec_q <= 1'b0;
      ivec_q <= 1'b0;
      ew_q   <= EW64;
      vl_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        sea_q  <= (major == 2'b00) && mbit && fb;
        ew_q   <= ew_i;
        bvec_q <= base_vec_i;
        ivec_q <= idx_vec_i;
        vl_q   <= vl_i;
        cnt_q  <= '0;
        if (vl_i == '0) done_q <= 1'b1;
        else            busy_q <= 1'b1;
      end else if (fire) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  logic [AW-1:0] idx_ext;
  always_comb begin
    case (ew_q)
      EW32:    idx_ext = {{(AW-32){sea_q & idx_val_i[31]}}, idx_val_i[31:0]};
      EW16:    idx_ext = {{(AW-16){sea_q & idx_val_i[15]}}, idx_val_i[15:0]};
      EW8:     idx_ext = {{(AW-8){sea_q & idx_val_i[7]}}, idx_val_i[7:0]};
      default: idx_ext = idx_val_i;
    endcase
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign req_valid_o = busy_q;
  assign req_elem_o  = cnt_q;
  assign base_sel_o  = bvec_q ? cnt_q : '0;
  assign idx_sel_o   = ivec_q ? cnt_q : '0;
  assign req_addr_o  = base_val_i + idx_ext;
endmodule

module vidx_addr_seq_chk #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid_o,
  input logic           req_ready_i,
  input logic [VLW-1:0] req_elem_o,
  input logic           done_o,
  input logic           bvec_q,
  input logic           ivec_q,
  input logic [VLW-1:0] base_sel_o,
  input logic [VLW-1:0] idx_sel_o,
  input logic           m_normal_o,
  input logic           m_sea_o,
  input logic           m_ffirst_o,
  input logic           m_sat_o
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_elem_o));

  assert_elem_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> done_o || (req_valid_o && req_elem_o == $past(req_elem_o) + 1'b1));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  assert_one_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_normal_o, m_sea_o, m_ffirst_o, m_sat_o}));

  assert_scalar_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !bvec_q |-> base_sel_o == '0);

  assert_scalar_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !ivec_q |-> idx_sel_o == '0);
endmodule

bind vidx_addr_seq vidx_addr_seq_chk #(.VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_elem_o(req_elem_o), .done_o(done_o), .bvec_q(bvec_q), .ivec_q(ivec_q),
  .base_sel_o(base_sel_o), .idx_sel_o(idx_sel_o), .m_normal_o(m_normal_o),
  .m_sea_o(m_sea_o), .m_ffirst_o(m_ffirst_o), .m_sat_o(m_sat_o)
);

// File: tb/vidx_addr_seq_test.sv
module vidx_addr_seq_test;
  localparam int AW = 64, VLW = 7;

  logic clk = 0, rst_n = 0, start = 0, rc = 0, bvec = 0, ivec = 0, ready = 0;
  logic [4:0] mode = 0;
  logic [1:0] ew = 0;
  logic [VLW-1:0] vl = 0;
  logic [VLW-1:0] bsel, isel, relem;
  logic [AW-1:0] bval, ival, raddr;
  logic busy, rvalid, done;
  logic f_norm, f_sea, f_ff, f_sat, f_sgn, f_inv, f_dz, f_sz, f_seaf, f_rc1;
  logic [1:0] f_cr;

  logic [AW-1:0] base_rf [0:15];
  logic [AW-1:0] idx_rf  [0:15];
  assign bval = base_rf[bsel[3:0]];
  assign ival = idx_rf[isel[3:0]];

  always #5 clk = ~clk;

  vidx_addr_seq #(.AW(AW), .VLW(VLW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode), .rc_i(rc), .ew_i(ew),
    .base_vec_i(bvec), .idx_vec_i(ivec), .vl_i(vl), .busy_o(busy),
    .base_sel_o(bsel), .idx_sel_o(isel), .base_val_i(bval), .idx_val_i(ival),
    .req_valid_o(rvalid), .req_ready_i(ready), .req_addr_o(raddr), .req_elem_o(relem),
    .done_o(done), .m_normal_o(f_norm), .m_sea_o(f_sea), .m_ffirst_o(f_ff),
    .m_sat_o(f_sat), .m_sgn_o(f_sgn), .m_inv_o(f_inv), .m_dz_o(f_dz), .m_sz_o(f_sz),
    .m_sea_flag_o(f_seaf), .m_rc1_o(f_rc1), .m_crsel_o(f_cr)
  );

  int checks = 0, fails = 0, dones = 0;
  string tag = "R10";
  logic [AW+VLW-1:0] expq [$];

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] widen_idx(logic [AW-1:0] v, logic [1:0] code, logic sgn);
    int w;
    logic [AW-1:0] mask;
    if (code == 2'b00) return v;
    w = 64 >> code;
    mask = (64'd1 << w) - 1;
    v = v & mask;
    if (sgn && v[w-1]) v = v | ~mask;
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) dones++;
    if (rst_n && rvalid && ready) begin
      if (expq.size() == 0) check({tag, " unexpected request"}, {raddr, relem}, 0);
      else check(tag, {raddr, relem}, expq.pop_front());
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      ready = ($urandom % 3) != 0;
    end
  end

  task automatic run(string req, int n, logic [4:0] m, logic [1:0] c, logic bv, logic iv);
    logic sea;
    int d0;
    sea = (m[4:3] == 2'b00) && m[2] && m[0];
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] b, x;
      b = base_rf[bv ? i : 0];
      x = idx_rf[iv ? i : 0];
      expq.push_back({b + widen_idx(x, c, sea), VLW'(i)});
    end
    tag = req;
    d0 = dones;
    @(posedge clk); #1;
    mode = m; ew = c; bvec = bv; ivec = iv; vl = VLW'(n); start = 1;
    @(posedge clk); #1;
    start = 0;
    while (dones == d0) @(negedge clk);
    check({req, " queue drained at done"}, expq.size(), 0);
    @(negedge clk);
    check("R11 done is one pulse", dones - d0, 1);
    expq.delete();
  endtask

  task automatic dec(string req, logic [4:0] m, logic r, logic [13:0] exp);
    mode = m; rc = r; #1;
    check(req, {f_norm, f_sea, f_ff, f_sat, f_sgn, f_inv, f_dz, f_sz, f_seaf, f_rc1, f_cr}, exp);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      base_rf[i] = 64'h1000_0000_0000_0000 + 64'(i) * 64'h100;
      idx_rf[i]  = 64'h1234_5678_9abc_de80 ^ (64'(i) * 64'h0101_0101_0101_0111);
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {rvalid, done, busy}, 0);
    rst_n = 1;

    // R2 flag order: normal sea ffirst sat sgn inv dz sz seaflag rc1 crsel[1:0]
    dec("R2 normal", 5'b00011, 0, 14'b1000_0011_0000);
    dec("R2 sea", 5'b00111, 0, 14'b0100_0010_1000);
    dec("R3 ffirst rc0", 5'b01111, 0, 14'b0010_0110_0100);
    dec("R3 ffirst rc1", 5'b01010, 1, 14'b0010_0000_0010);
    dec("R4 sat signed", 5'b10101, 0, 14'b0001_1001_0000);
    dec("R4 major 11", 5'b11111, 1, 14'b0000_0000_0000);
    rc = 0;

    run("R5 zero-ext w32", 5, 5'b00000, 2'b01, 1, 1);
    run("R5 zero-ext w8 sat", 6, 5'b10101, 2'b11, 1, 1);
    run("R5 sea flag clear w16", 4, 5'b00100, 2'b10, 1, 1);
    run("R6 sign-ext w8", 7, 5'b00101, 2'b11, 1, 1);
    run("R6 sign-ext w16", 5, 5'b00101, 2'b10, 0, 1);
    run("R6 sign-ext w32", 5, 5'b00101, 2'b01, 1, 0);
    run("R7 full width sea", 4, 5'b00101, 2'b00, 1, 1);
    run("R8 scalar base vector idx", 6, 5'b00000, 2'b00, 0, 1);
    run("R12 scalar splat", 5, 5'b00000, 2'b00, 0, 0);

    base_rf[0] = 64'hffff_ffff_ffff_fff0;
    idx_rf[0]  = 64'h0000_0000_0000_0020;
    run("R9 wrap", 3, 5'b00000, 2'b00, 0, 0);
    idx_rf[0] = 64'h0000_0000_0000_00f0;
    run("R9 wrap signed w8", 2, 5'b00101, 2'b11, 1, 0);

    run("R11 vl zero", 0, 5'b00000, 2'b00, 1, 1);
    check("R11 no request after vl zero", rvalid, 0);
    run("R10 long run", 16, 5'b00000, 2'b10, 1, 1);
    finish_up();
  end
endmodule